// File: doc/BRIEF.md
# Frame Offset Measurement Unit

This unit measures how far a frame evaluation signal, taken from a delayed serial stream, trails the local frame pulse. Software uses the result to calibrate the input delay of each stream. A measurement begins when the start bit goes from 0 to 1. That transition clears the previous result and arms the unit. The next frame pulse starts a count of master clock cycles. The count stops at the first rising edge of the evaluation input. The unit then stores the count and the half of the clock period in which the edge arrived, and it raises a completion flag.

The evaluation input is sampled on both clock edges, which gives half-cycle resolution. If no rising edge arrives within one full frame (2^CNT_W cycles), the count saturates and the completion flag is still raised. The result does not change until the next 0-to-1 transition of the start bit.

Top module: `frame_offset_meter`

## Requirements
- R1: After reset, count_o, phase_o and done_o are all 0.
- R2: The rising clock edge that sees start_i at 1, after it was 0 on the previous rising edge, clears count_o, phase_o and done_o. All three read 0 after that edge, and the unit is armed.
- R3: Counting starts at the first rising clock edge, after arming, at which frame_pulse_i is sampled high. Evaluation edges before that edge do not affect the result. A frame pulse sampled on the same edge as the start transition is ignored.
- R4: Let P0 be the rising clock edge at which the frame pulse is taken. If the evaluation edge is detected at rising edge P0+k (k from 1 to 2^CNT_W), then count_o reads k-1 after that edge.
- R5: phase_o is 1 when the evaluation input rose in the high phase, between a rising clock edge and the falling edge that follows it. phase_o is 0 when the input rose in the low phase, between a falling edge and the next rising edge.
- R6: done_o goes to 1 on the same rising edge that loads count_o and phase_o. All three then stay unchanged, whatever frame_pulse_i and eval_i do, until the next 0-to-1 transition of start_i.
- R7: If no evaluation edge is detected up to and including rising edge P0+2^CNT_W, the result is loaded on that edge with count_o all ones, phase_o 0 and done_o 1. done_o is still 0 after edge P0+2^CNT_W-1.
- R8: Only a 0-to-1 transition of eval_i counts as an evaluation edge. An input that is already high at the frame pulse, or that only falls, gives the saturated result.
- R9: A 0-to-1 transition of start_i during a measurement abandons that measurement, clears the result and re-arms the unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock; both edges sample eval_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start bit level; its 0-to-1 transition arms a measurement |
| frame_pulse_i | input | 1 | Local frame pulse, active high |
| eval_i | input | 1 | Frame evaluation input from the delayed stream |
| count_o | output | CNT_W | Measured offset in whole clock cycles |
| phase_o | output | 1 | 1: edge in the high clock phase, 0: edge in the low clock phase |
| done_o | output | 1 | Measurement complete |

## Verification
A 5-bit configuration is swept over every cycle offset from 0 to the frame limit, with the evaluation edge placed first in the high phase and then in the low phase. Checking the count and the phase together catches off-by-one faults in the count and a swap of the phase sense. Other patterns are an evaluation pulse that comes before the frame pulse, an input held high across the frame pulse, an input that only falls, and no edge at all. These separate true edge detection from level detection, and show that saturation lands exactly on the frame limit. A restart part-way through a measurement, and extra edges and pulses after completion, show that the result is cleared only by the start transition and otherwise holds.

// File: rtl/fom_pkg.sv
package fom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2
  } fom_state_e;
endpackage

// File: rtl/fom_edge_sampler.sv
module fom_edge_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eval_i,
  output logic hit_o,
  output logic hit_high_o
);
  logic eval_pos_q;
  logic eval_neg_q;

  // falling-edge sample reflects the level at the end of the high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eval_neg_q <= 1'b0;
    else         eval_neg_q <= eval_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eval_pos_q <= 1'b0;
    else         eval_pos_q <= eval_i;
  end

  assign hit_o      = !eval_pos_q && (eval_neg_q || eval_i);
  assign hit_high_o = eval_neg_q;
endmodule

// File: rtl/fom_counter.sv
module fom_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (inc_i && !at_max_o) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == CntMax);

  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !at_max_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/fom_ctrl.sv
module fom_ctrl
  import fom_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             frame_pulse_i,
  input  logic             hit_i,
  input  logic             hit_high_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             at_max_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic [CNT_W-1:0] count_o,
  output logic             phase_o,
  output logic             done_o
);
  fom_state_e       state_q;
  logic             start_q;
  logic             start_rise;
  logic [CNT_W-1:0] count_q;
  logic             phase_q;
  logic             done_q;

  assign start_rise = start_i && !start_q;
  assign cnt_clr_o  = start_rise || (state_q == ST_ARMED && frame_pulse_i);
  assign cnt_inc_o  = (state_q == ST_COUNT) && !hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      state_q <= ST_IDLE;
      count_q <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= start_i;
      if (start_rise) begin
        state_q <= ST_ARMED;
        count_q <= '0;
        phase_q <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ARMED: if (frame_pulse_i) state_q <= ST_COUNT;
          ST_COUNT: begin
            if (hit_i) begin
              count_q <= cnt_i;
              phase_q <= hit_high_i;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (at_max_i) begin
              count_q <= '1;
              phase_q <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign count_o = count_q;
  assign phase_o = phase_q;
  assign done_o  = done_q;

  assert_clear_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rise |=> (!done_o && count_o == '0 && !phase_o));

  assert_hold_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_rise) |=> (done_o && $stable(count_o) && $stable(phase_o)));

  assert_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && at_max_i && !hit_i && !start_rise) |=>
      (done_o && (&count_o) && !phase_o));

  assert_done_from_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(state_q) == ST_COUNT));
endmodule

// File: rtl/frame_offset_meter.sv
module frame_offset_meter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             frame_pulse_i,
  input  logic             eval_i,
  output logic [CNT_W-1:0] count_o,
  output logic             phase_o,
  output logic             done_o
);
  logic             hit;
  logic             hit_high;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             at_max;
  logic [CNT_W-1:0] cnt;

  fom_edge_sampler i_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eval_i     (eval_i),
    .hit_o      (hit),
    .hit_high_o (hit_high)
  );

  fom_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .inc_i    (cnt_inc),
    .cnt_o    (cnt),
    .at_max_o (at_max)
  );

  fom_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .frame_pulse_i (frame_pulse_i),
    .hit_i         (hit),
    .hit_high_i    (hit_high),
    .cnt_i         (cnt),
    .at_max_i      (at_max),
    .cnt_clr_o     (cnt_clr),
    .cnt_inc_o     (cnt_inc),
    .count_o       (count_o),
    .phase_o       (phase_o),
    .done_o        (done_o)
  );
endmodule

// File: tb/test_frame_offset_meter.sv
`timescale 1ns/1ps
module test_frame_offset_meter;
  localparam int CNT_W = 5;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic fp = 1'b0;
  logic eval = 1'b0;
  logic [CNT_W-1:0] count;
  logic phase;
  logic done;
  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  frame_offset_meter #(.CNT_W(CNT_W)) i_frame_offset_meter (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .frame_pulse_i(fp),
    .eval_i(eval), .count_o(count), .phase_o(phase), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_res(input string req, input int c, input int ph, input int dn);
    check({req, " count"}, int'(count), c);
    check({req, " phase"}, int'(phase), ph);
    check({req, " done"}, int'(done), dn);
  endtask

  // start low then high at falling edges; result must clear after the rising edge
  task automatic arm();
    @(negedge clk) start = 1'b0;
    @(negedge clk) start = 1'b1;
    @(posedge clk); #1;
    check_res("R2 clear", 0, 0, 0);
  endtask

  // frame pulse taken at next rising edge P0; returns at P0+1ns
  task automatic pulse();
    @(negedge clk) fp = 1'b1;
    @(posedge clk); #1 fp = 1'b0;
  endtask

  task automatic edge_at(input int c, input bit hi);
    if (c > 0) begin
      repeat (c) @(posedge clk);
      #1;
    end
    if (!hi) #2.5;
    eval = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic measure(input int c, input bit hi);
    eval = 1'b0;
    arm();
    pulse();
    edge_at(c, hi);
    check_res(hi ? "R4 R5 high" : "R4 R5 low", c, hi ? 1 : 0, 1);
    eval = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #7 check_res("R1 reset", 0, 0, 0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (2) @(posedge clk); #1;
    check_res("R1 idle", 0, 0, 0);

    // R4 R5: full sweep of offsets, both phases
    for (int c = 0; c <= MAXC; c++) begin
      measure(c, 1'b1);
      measure(c, 1'b0);
    end

    // R6: extra edges and frame pulses after completion leave result intact
    measure(9, 1'b1);
    pulse();
    edge_at(2, 1'b0);
    eval = 1'b0;
    edge_at(3, 1'b1);
    eval = 1'b0;
    repeat (3) @(posedge clk); #1;
    check_res("R6 hold", 9, 1, 1);

    // R3: evaluation pulse before the frame pulse is ignored
    eval = 1'b0;
    arm();
    @(negedge clk) eval = 1'b1;
    @(negedge clk) eval = 1'b0;
    repeat (2) @(posedge clk); #1;
    check_res("R3 pre-pulse edge", 0, 0, 0);
    pulse();
    edge_at(5, 1'b1);
    check_res("R3 count after pulse", 5, 1, 1);
    eval = 1'b0;

    // R3: frame pulse coincident with start transition is ignored
    @(negedge clk) start = 1'b0;
    @(negedge clk) begin start = 1'b1; fp = 1'b1; end
    @(negedge clk) fp = 1'b0;
    repeat (4) @(posedge clk); #1 eval = 1'b1;
    @(posedge clk); #1;
    check_res("R3 coincident pulse", 0, 0, 0);
    eval = 1'b0;
    pulse();
    edge_at(6, 1'b0);
    check_res("R3 later pulse", 6, 0, 1);
    eval = 1'b0;

    // R7: no edge -> saturation exactly at the frame limit
    arm();
    pulse();
    repeat (MAXC) @(posedge clk); #1;
    check_res("R7 before limit", 0, 0, 0);
    @(posedge clk); #1;
    check_res("R7 saturated", MAXC, 0, 1);

    // R8: input already high at the frame pulse
    eval = 1'b1;
    arm();
    pulse();
    repeat (MAXC + 1) @(posedge clk); #1;
    check_res("R8 held high", MAXC, 0, 1);

    // R8: input that only falls
    arm();
    pulse();
    edge_at(3, 1'b1);
    eval = 1'b0;
    repeat (MAXC - 3) @(posedge clk); #1;
    check_res("R8 falling only", MAXC, 0, 1);

    // R9: restart part-way through counting
    eval = 1'b0;
    arm();
    pulse();
    repeat (4) @(posedge clk);
    measure(7, 1'b1);
    measure(0, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule